// File: doc/BRIEF.md
# Interval Timer Channel Read-Back Latch

This block forms the read side of one 16-bit down-counter channel in a three-channel interval timer. It watches the processor bus for read-back commands written to the control address. When a command selects this channel, the block freezes the current count, an 8-bit status byte, or both. Later processor reads of the channel's address then return those frozen values one byte at a time. Once every frozen byte has been read, reads return the running count again.

The bus is a plain strobe interface with chip select, read and write strobes, a 2-bit address, and an 8-bit input data bus. The block has no back-pressure. A read is answered in the same cycle its strobe becomes active, and the read only counts as consumed when its strobe ends. The counter core supplies the running count, the output pin level, the null-count flag, the counting mode, the BCD flag, and the byte-access setting. The block drives the read byte together with an output enable for the shared three-state bus.

Top module: `pit_readback`

## Requirements
- R1: When chip select is high, or when both strobes are high, the block does not drive the bus: `dout_oe` is 0 and `dout` is 0.
- R2: A read at address 3, or at another channel's address, leaves `dout_oe` at 0. A write at address 3 with bits 7:6 = 11 is a read-back command.
- R3: In a read-back command, bit 1+k selects channel k and bit 0 must be 0. A command that does not select this channel has no effect. A control word at address 3 whose bits 7:6 are not 11 also has no effect.
- R4: Bit 5 = 0 latches the count and bit 4 = 0 latches the status. With both bits at 0, one command latches both. The count captured is the running count in the clock cycle where the write strobe first becomes active.
- R5: A count latch or status latch command that arrives while the same value is still held and unread is ignored. The first captured value is kept.
- R6: While the status is held, the next read returns the status byte, whichever of the two was latched first.
- R7: The status byte holds, from bit 7 down to bit 0: the output pin level, the null-count flag, the two access bits, the three mode bits, and the BCD bit.
- R8: With access setting 11 (two bytes), a held count is read least significant byte first, then most significant byte. The hold is released after the second byte.
- R9: With access setting 01, one read returns the low byte of the held count. With access setting 10, one read returns the high byte. In both cases that single read releases the hold.
- R10: When nothing is held, reads return the running count. With access setting 11, successive reads alternate low byte, then high byte.
- R11: After reset nothing is held and the next two-byte read returns the low byte. A read takes effect on the clock after its strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address (0..2 channels, 3 control) |
| din | input | 8 | Write data from the processor |
| live_count | input | 16 | Running count of this channel |
| out_level | input | 1 | Current output pin level |
| null_cnt | input | 1 | Null-count flag from the counter core |
| acc_mode | input | 2 | Byte-access setting: 01 low, 10 high, 11 low then high |
| ctr_mode | input | 3 | Programmed counting mode |
| bcd | input | 1 | Decimal counting flag |
| dout | output | 8 | Byte driven on reads, 0 when not driving |
| dout_oe | output | 1 | Drive enable for the bus |

## Verification
The assertions assume the strobes are glitch-free, that read and write never go low together, and that the address stays stable while a strobe is active. They also assume a read-back command never coincides with the end of a read to this channel. The bench drives each access as one cycle of active strobe followed by at least one idle cycle. It changes the running count and status inputs only between accesses, so each capture cycle and each read-consume cycle can be located exactly.

// File: rtl/pit_rb_pkg.sv
package pit_rb_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_mode_e;

  localparam logic [1:0] RB_SELECT = 2'b11;

  function automatic logic [7:0] pack_status(input logic pin, input logic nul,
                                             input logic [1:0] acc, input logic [2:0] md,
                                             input logic dec);
    return {pin, nul, acc, md, dec};
  endfunction
endpackage

// File: rtl/pit_rb_decode.sv
module pit_rb_decode #(
  parameter int CHAN_ID = 0,
  parameter int NUM_CH  = 3,
  parameter int ADDR_W  = 2,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic              rd_act,
  output logic              rd_done,
  output logic              cmd_cnt,
  output logic              cmd_stat
);
  import pit_rb_pkg::*;
  localparam logic [ADDR_W-1:0] MY_ADDR   = ADDR_W'(CHAN_ID);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;
  localparam logic [NUM_CH-1:0] MY_BIT    = NUM_CH'(1) << CHAN_ID;
  localparam int                MASK_LSB  = 1;

  logic rd_q, wr_now, wr_q, wr_start, cmd_stb;
  logic [NUM_CH-1:0] mask;
  logic [BYTE_W-1:NUM_CH+1] top_bits;

  assign rd_act   = !cs_n && !rd_n && wr_n && (addr == MY_ADDR);
  assign wr_now   = !cs_n && !wr_n && rd_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_now;
    end
  end

  assign rd_done  = rd_q && !rd_act;
  assign wr_start = wr_now && !wr_q && (addr == CTRL_ADDR);
  assign mask     = din[MASK_LSB +: NUM_CH];
  assign top_bits = din[BYTE_W-1:NUM_CH+1];
  assign cmd_stb  = wr_start && (top_bits[BYTE_W-1 -: 2] == RB_SELECT) &&
                    (|(mask & MY_BIT)) && !din[0];
  assign cmd_cnt  = cmd_stb && !top_bits[BYTE_W-3];
  assign cmd_stat = cmd_stb && !top_bits[BYTE_W-4];
endmodule

// File: rtl/pit_rb_hold.sv
module pit_rb_hold #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_cnt,
  input  logic              cmd_stat,
  input  logic              rd_done,
  input  logic [1:0]        acc_mode,
  input  logic [CNT_W-1:0]  live_count,
  input  logic [BYTE_W-1:0] status_now,
  output logic              cnt_held,
  output logic              stat_held,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              byte_hi
);
  import pit_rb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_held  <= 1'b0;
      stat_held <= 1'b0;
      cnt_q     <= '0;
      stat_q    <= '0;
      byte_hi   <= 1'b0;
    end else begin
      if (rd_done) begin
        if (stat_held) begin
          stat_held <= 1'b0;
        end else if (acc_mode == ACC_WORD) begin
          byte_hi <= !byte_hi;
          if (byte_hi) cnt_held <= 1'b0;
        end else begin
          cnt_held <= 1'b0;
        end
      end
      if (cmd_cnt && !cnt_held) begin
        cnt_held <= 1'b1;
        cnt_q    <= live_count;
      end
      if (cmd_stat && !stat_held) begin
        stat_held <= 1'b1;
        stat_q    <= status_now;
      end
    end
  end
endmodule

// File: rtl/pit_rb_mux.sv
module pit_rb_mux #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              rd_act,
  input  logic [1:0]        acc_mode,
  input  logic              byte_hi,
  input  logic              cnt_held,
  input  logic              stat_held,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [BYTE_W-1:0] stat_q,
  input  logic [CNT_W-1:0]  live_count,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);
  import pit_rb_pkg::*;
  logic [CNT_W-1:0]  src;
  logic              pick_hi;
  logic [BYTE_W-1:0] sel_byte;

  always_comb begin
    src      = cnt_held ? cnt_q : live_count;
    pick_hi  = (acc_mode == ACC_HI) || ((acc_mode == ACC_WORD) && byte_hi);
    sel_byte = pick_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
    if (stat_held) sel_byte = stat_q;
  end

  assign dout    = rd_act ? sel_byte : '0;
  assign dout_oe = rd_act;
endmodule

// File: rtl/pit_readback.sv
module pit_readback #(
  parameter int CHAN_ID = 0,
  parameter int NUM_CH  = 3,
  parameter int BYTE_W  = 8,
  localparam int CNT_W  = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] din,
  input  logic [CNT_W-1:0]  live_count,
  input  logic              out_level,
  input  logic              null_cnt,
  input  logic [1:0]        acc_mode,
  input  logic [2:0]        ctr_mode,
  input  logic              bcd,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe
);
  import pit_rb_pkg::*;

  logic rd_act, rd_done, cmd_cnt, cmd_stat;
  logic cnt_held, stat_held, byte_hi;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] stat_q, status_now;

  assign status_now = BYTE_W'(pack_status(out_level, null_cnt, acc_mode, ctr_mode, bcd));

  pit_rb_decode #(.CHAN_ID(CHAN_ID), .NUM_CH(NUM_CH), .ADDR_W(2), .BYTE_W(BYTE_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .rd_act(rd_act), .rd_done(rd_done), .cmd_cnt(cmd_cnt), .cmd_stat(cmd_stat));

  pit_rb_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cmd_cnt(cmd_cnt), .cmd_stat(cmd_stat), .rd_done(rd_done),
    .acc_mode(acc_mode), .live_count(live_count), .status_now(status_now),
    .cnt_held(cnt_held), .stat_held(stat_held), .cnt_q(cnt_q), .stat_q(stat_q),
    .byte_hi(byte_hi));

  pit_rb_mux #(.BYTE_W(BYTE_W)) u_mux (
    .rd_act(rd_act), .acc_mode(acc_mode), .byte_hi(byte_hi), .cnt_held(cnt_held),
    .stat_held(stat_held), .cnt_q(cnt_q), .stat_q(stat_q), .live_count(live_count),
    .dout(dout), .dout_oe(dout_oe));
endmodule

// File: rtl/pit_readback_chk.sv
module pit_readback_chk #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [1:0]        addr,
  input logic [BYTE_W-1:0] dout,
  input logic              dout_oe,
  input logic              cnt_held,
  input logic              stat_held,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [BYTE_W-1:0] stat_q,
  input logic              rd_done
);
  assert_quiet_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || (rd_n && wr_n)) |-> (!dout_oe && dout == '0));

  assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'b11) |-> !dout_oe);

  assert_keep_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_held) && cnt_held) |-> $stable(cnt_q));

  assert_status_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_held && dout_oe) |-> (dout == stat_q));

  assert_release_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_held) |-> $past(rd_done));
endmodule

bind pit_readback pit_readback_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
  .dout(dout), .dout_oe(dout_oe), .cnt_held(cnt_held), .stat_held(stat_held),
  .cnt_q(cnt_q), .stat_q(stat_q), .rd_done(rd_done));

// File: tb/pit_readback_test.sv
module pit_readback_test;
  localparam int PERIOD = 10;
  localparam logic [1:0] ME = 2'd1;
  localparam logic [1:0] CTRL = 2'd3;

  logic clk = 0, rst_n = 0, cs_n = 1, rd_n = 1, wr_n = 1;
  logic [1:0] addr = 0, acc_mode = 2'b11;
  logic [7:0] din = 0;
  logic [15:0] live_count = 0;
  logic out_level = 0, null_cnt = 0, bcd = 0;
  logic [2:0] ctr_mode = 0;
  logic [7:0] dout;
  logic dout_oe;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  pit_readback #(.CHAN_ID(1)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .live_count(live_count), .out_level(out_level), .null_cnt(null_cnt),
    .acc_mode(acc_mode), .ctr_mode(ctr_mode), .bcd(bcd), .dout(dout), .dout_oe(dout_oe));

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic o);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1; d = dout; o = dout_oe;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] exp);
    logic [7:0] d; logic o;
    bus_rd(ME, d, o);
    chk(tag, {o, d}, {1'b1, exp});
  endtask

  task automatic t_reset;
    #1; chk("R11 reset idle", {dout_oe, dout}, 9'h000);
    live_count = 16'h1234; acc_mode = 2'b11;
    rd_expect("R11 first word read low", 8'h34);
    rd_expect("R10 live high", 8'h12);
  endtask

  task automatic t_noop;
    logic [7:0] d; logic o;
    @(negedge clk); cs_n = 1; rd_n = 0; addr = ME; #1;
    chk("R1 cs high", {dout_oe, dout}, 9'h000);
    @(negedge clk); cs_n = 0; rd_n = 1; wr_n = 1; #1;
    chk("R1 both strobes high", {dout_oe, dout}, 9'h000);
    @(negedge clk); cs_n = 1;
    bus_rd(CTRL, d, o); chk("R2 ctrl read", {o, d}, 9'h000);
    bus_rd(2'd0, d, o); chk("R2 other chan read", {o, d}, 9'h000);
  endtask

  task automatic t_both;
    acc_mode = 2'b11; live_count = 16'hABCD;
    out_level = 1; null_cnt = 0; ctr_mode = 3'b101; bcd = 1;
    bus_wr(CTRL, 8'hC4);
    live_count = 16'h1122; out_level = 0;
    rd_expect("R7 status layout", 8'hBB);
    rd_expect("R8 latched low", 8'hCD);
    rd_expect("R8 latched high", 8'hAB);
    rd_expect("R10 live low after release", 8'h22);
    rd_expect("R10 live high after release", 8'h11);
  endtask

  task automatic t_order;
    acc_mode = 2'b11; live_count = 16'h4455;
    out_level = 0; null_cnt = 1; ctr_mode = 3'b010; bcd = 0;
    bus_wr(CTRL, 8'hD4);
    live_count = 16'h0000;
    bus_wr(CTRL, 8'hE4);
    rd_expect("R6 status before earlier count", 8'h74);
    rd_expect("R4 count low", 8'h55);
    rd_expect("R4 count high", 8'h44);
  endtask

  task automatic t_repeat;
    acc_mode = 2'b11; live_count = 16'h2211;
    out_level = 0; null_cnt = 1; ctr_mode = 3'b010; bcd = 0;
    bus_wr(CTRL, 8'hC4);
    live_count = 16'h3333; out_level = 1;
    bus_wr(CTRL, 8'hC4);
    rd_expect("R5 first status kept", 8'h74);
    rd_expect("R5 first count low kept", 8'h11);
    rd_expect("R5 first count high kept", 8'h22);
  endtask

  task automatic t_mask;
    acc_mode = 2'b11; live_count = 16'h6677;
    bus_wr(CTRL, 8'hCA);
    bus_wr(CTRL, 8'hC5);
    bus_wr(CTRL, 8'h74);
    live_count = 16'h8899;
    rd_expect("R3 unselected ignored low", 8'h99);
    rd_expect("R3 unselected ignored high", 8'h88);
  endtask

  task automatic t_single;
    acc_mode = 2'b01; live_count = 16'h5678;
    bus_wr(CTRL, 8'hD4);
    live_count = 16'h9AB9;
    rd_expect("R9 low only latched", 8'h78);
    rd_expect("R9 low only released", 8'hB9);
    acc_mode = 2'b10; live_count = 16'h5678;
    bus_wr(CTRL, 8'hD4);
    live_count = 16'h9AB9;
    rd_expect("R9 high only latched", 8'h56);
    rd_expect("R9 high only released", 8'h9A);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_noop;
    t_both;
    t_order;
    t_repeat;
    t_mask;
    t_single;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule